// File: doc/BRIEF.md
# Row-Hit-First Burst Selector

This block picks the next burst to send to a DRAM channel from a fixed array of pending requests. Each slot carries a valid bit, a rank, a bank and a row. The whole array is one queue, either reads or writes, and a direction input tells the block which kind it holds. For every rank and bank pair the caller supplies whether a row is open and which one, plus the earliest times at which a read column command, a write column command and an activate are allowed. The caller also supplies a target column time and the latest activate time that can still be hidden behind the burst now on the bus.

The choice has three levels. The first is a row hit whose column command can go out by the target time. The second is the oldest row hit whose bank is open but not yet ready. The third is a row miss to one of the banks that can be activated soonest. The decision is combinational. It is captured in output registers when the select strobe is high, together with the predicted column-issue time. Command generation, bus turnaround and refresh sequencing happen outside this block; their effect arrives as the timing inputs.

Top module: `rowhit_sched`

## Requirements
- R1: A valid, refresh-idle entry whose bank has its row open, whose row matches that open row, and whose column-allowed time is at or below `min_col_at` is a seamless hit. The lowest-index such entry is chosen with kind code 1, its column-allowed time is reported, and the scan stops there.
- R2: If there is no seamless hit, the lowest-index open-row hit is chosen with kind code 2 and its column-allowed time is reported, unless R5 applies.
- R3: Entries whose rank has `rank_ref_idle` low are not selected. Their banks are left out of the earliest-bank calculation.
- R4: Row misses compete through a bank mask. A miss's column time is the larger of the bank's column-allowed time and its activate time plus `TRCD`. Among banks that have ready entries, the mask holds the banks whose miss column time is at or below `min_col_at`, or, if there are none, the banks that share the minimum activate time. The lowest-index miss to a masked bank is picked with kind code 3 and reports its miss column time.
- R5: The hidden flag is the comparison "activate time at or below `hidden_act_max`" for the highest-numbered masked bank. When the flag is set, the masked miss wins even over an earlier prepped hit, and no later hit replaces it. When the flag is clear, any open-row hit wins over the miss.
- R6: When no valid entry has an idle rank, `sel_valid` is 0 and `sel_kind` is 0 after the strobe. Otherwise `sel_valid` is 1.
- R7: Outputs change only on a clock edge at which `sel_strobe` is high. They hold otherwise.
- R8: A synchronous active-low reset clears `sel_valid`, `sel_idx`, `sel_col_at` and `sel_kind` to 0.
- R9: A bank that meets the column time clears from the mask any bank placed there earlier only for its early activate time.
- R10: `rd_queue` = 1 uses the per-bank read column times and `rd_queue` = 0 uses the write column times, both for the hit test and for the miss column time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_strobe | input | 1 | Capture the current decision |
| rd_queue | input | 1 | 1: read queue, 0: write queue |
| min_col_at | input | TW | Target column time for a seamless burst |
| hidden_act_max | input | TW | Latest activate time still hidden behind the current burst |
| q_valid | input | QDEPTH | Slot valid bits |
| q_rank | input | QDEPTH*RW | Rank per slot |
| q_bank | input | QDEPTH*BW | Bank per slot |
| q_row | input | QDEPTH*ROWW | Row per slot |
| rank_ref_idle | input | RANKS | Rank is idle with respect to refresh |
| bank_open | input | NB | Bank has a row open (index rank*BANKS+bank) |
| bank_open_row | input | NB*ROWW | Open row per bank |
| bank_rd_at | input | NB*TW | Earliest read column time per bank |
| bank_wr_at | input | NB*TW | Earliest write column time per bank |
| bank_act_at | input | NB*TW | Earliest activate time per bank |
| sel_valid | output | 1 | A slot was chosen |
| sel_idx | output | QW | Chosen slot |
| sel_col_at | output | TW | Predicted column-issue time |
| sel_kind | output | 2 | 0 none, 1 seamless, 2 prepped, 3 earliest-bank miss |

## Verification
The bench builds the block with four slots, two ranks of two banks, 8-bit rows and times, and `TRCD` = 3. The bank state is small enough to fix by hand, yet it holds a seamless open bank, a slow open bank, a closed bank that meets the column time with an exposed activate, and one that meets it with a hidden activate. That makes every priority level, the mask clearing, the hidden-flag override and the refresh exclusion reachable with two or three queue entries. Each expected result can be traced by hand.

// File: rtl/rowhit_pkg.sv
// Shared types for the row-hit-first selector.
// Assumes: the kind codes are visible on the top-level port and must stay fixed.
package rowhit_pkg;
    typedef enum logic [1:0] {
        PICK_NONE     = 2'd0,
        PICK_SEAMLESS = 2'd1,
        PICK_PREPPED  = 2'd2,
        PICK_EARLIEST = 2'd3
    } pick_kind_e;
endpackage

// File: rtl/rowhit_coltime.sv
// Per-bank column timing: picks the read or write column-allowed time and
// forms the column time a row miss would reach after activate plus TRCD.
// Assumes: times do not wrap within TW bits.
module rowhit_coltime #(
    parameter int NB   = 4,
    parameter int TW   = 16,
    parameter int TRCD = 4
) (
    input  logic             rd_queue,
    input  logic [NB*TW-1:0] bank_rd_at,
    input  logic [NB*TW-1:0] bank_wr_at,
    input  logic [NB*TW-1:0] bank_act_at,
    output logic [NB*TW-1:0] col_ok,
    output logic [NB*TW-1:0] miss_col
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [TW-1:0] col_b;
        logic [TW-1:0] act_rdy;
        // Direction selects which column constraint applies.
        assign col_b   = rd_queue ? bank_rd_at[b*TW +: TW] : bank_wr_at[b*TW +: TW];
        // Column time after a fresh activate.
        assign act_rdy = bank_act_at[b*TW +: TW] + TW'(TRCD);
        assign col_ok[b*TW +: TW]   = col_b;
        assign miss_col[b*TW +: TW] = (act_rdy > col_b) ? act_rdy : col_b;
    end
endmodule

// File: rtl/rowhit_bankmask.sv
// Earliest-bank mask: among banks with ready entries, marks those whose miss
// column time is seamless, or failing that those with the minimum activate time.
// Also reports whether the last marked bank's activate hides behind the bus.
// Assumes: bank id = rank*BANKS + bank.
module rowhit_bankmask #(
    parameter int QDEPTH = 16,
    parameter int RANKS  = 2,
    parameter int BANKS  = 4,
    parameter int TW     = 16,
    localparam int NB    = RANKS * BANKS,
    localparam int RW    = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic [QDEPTH-1:0]    q_valid,
    input  logic [QDEPTH*RW-1:0] q_rank,
    input  logic [QDEPTH*BW-1:0] q_bank,
    input  logic [RANKS-1:0]     rank_ref_idle,
    input  logic [NB*TW-1:0]     bank_act_at,
    input  logic [NB*TW-1:0]     miss_col,
    input  logic [TW-1:0]        min_col_at,
    input  logic [TW-1:0]        hidden_act_max,
    output logic [NB-1:0]        mask,
    output logic                 hidden
);
    logic [NB-1:0] waiting;

    // Banks that have at least one entry whose rank is refresh-idle.
    always_comb begin
        int rk;
        int bid;
        waiting = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            rk  = int'(q_rank[i*RW +: RW]);
            bid = rk * BANKS + int'(q_bank[i*BW +: BW]);
            if (q_valid[i] && rank_ref_idle[rk]) waiting[bid] = 1'b1;
        end
    end

    // Walk banks in id order, keeping the seamless or earliest set.
    always_comb begin
        logic          found_seam;
        logic          new_seam;
        logic [TW-1:0] min_act;
        logic [TW-1:0] act;
        mask       = '0;
        hidden     = 1'b0;
        found_seam = 1'b0;
        new_seam   = 1'b0;
        min_act    = '1;
        act        = '0;
        for (int b = 0; b < NB; b++) begin
            if (waiting[b]) begin
                act      = bank_act_at[b*TW +: TW];
                new_seam = (miss_col[b*TW +: TW] <= min_col_at);
                if (new_seam || (!found_seam && act <= min_act)) begin
                    if (!found_seam && (new_seam || act < min_act)) mask = '0;
                    found_seam = found_seam | new_seam;
                    mask[b]    = 1'b1;
                    hidden     = (act <= hidden_act_max);
                    min_act    = act;
                end
            end
        end
    end
endmodule

// File: rtl/rowhit_scan.sv
// Queue scan in slot order: seamless hit stops the scan, otherwise the first
// prepped hit or the first miss to a masked bank, the miss winning over a
// hit only when its activate is hidden.
// Assumes: mask and hidden come from rowhit_bankmask for the same inputs.
module rowhit_scan
    import rowhit_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int RANKS  = 2,
    parameter int BANKS  = 4,
    parameter int ROWW   = 14,
    parameter int TW     = 16,
    localparam int NB    = RANKS * BANKS,
    localparam int RW    = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int QW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic [QDEPTH-1:0]      q_valid,
    input  logic [QDEPTH*RW-1:0]   q_rank,
    input  logic [QDEPTH*BW-1:0]   q_bank,
    input  logic [QDEPTH*ROWW-1:0] q_row,
    input  logic [RANKS-1:0]       rank_ref_idle,
    input  logic [NB-1:0]          bank_open,
    input  logic [NB*ROWW-1:0]     bank_open_row,
    input  logic [NB*TW-1:0]       col_ok,
    input  logic [NB*TW-1:0]       miss_col,
    input  logic [NB-1:0]          mask,
    input  logic                   hidden,
    input  logic [TW-1:0]          min_col_at,
    output logic                   pick_valid,
    output logic [QW-1:0]          pick_idx,
    output logic [TW-1:0]          pick_col,
    output pick_kind_e             pick_kind
);
    // Priority encode over the slots.
    always_comb begin
        logic done;
        logic found_hidden;
        logic found_prep;
        logic found_early;
        int   rk;
        int   bid;
        done         = 1'b0;
        found_hidden = 1'b0;
        found_prep   = 1'b0;
        found_early  = 1'b0;
        pick_valid   = 1'b0;
        pick_idx     = '0;
        pick_col     = '0;
        pick_kind    = PICK_NONE;
        for (int i = 0; i < QDEPTH; i++) begin
            rk  = int'(q_rank[i*RW +: RW]);
            bid = rk * BANKS + int'(q_bank[i*BW +: BW]);
            if (!done && q_valid[i] && rank_ref_idle[rk]) begin
                if (bank_open[bid] &&
                    bank_open_row[bid*ROWW +: ROWW] == q_row[i*ROWW +: ROWW]) begin
                    if (col_ok[bid*TW +: TW] <= min_col_at) begin
                        pick_valid = 1'b1;
                        pick_idx   = QW'(i);
                        pick_col   = col_ok[bid*TW +: TW];
                        pick_kind  = PICK_SEAMLESS;
                        done       = 1'b1;
                    end else if (!found_hidden && !found_prep) begin
                        pick_valid = 1'b1;
                        pick_idx   = QW'(i);
                        pick_col   = col_ok[bid*TW +: TW];
                        pick_kind  = PICK_PREPPED;
                        found_prep = 1'b1;
                    end
                end else if (!found_early && mask[bid]) begin
                    found_early  = 1'b1;
                    found_hidden = hidden;
                    if (hidden || !found_prep) begin
                        pick_valid = 1'b1;
                        pick_idx   = QW'(i);
                        pick_col   = miss_col[bid*TW +: TW];
                        pick_kind  = PICK_EARLIEST;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rowhit_sched.sv
// Top of the row-hit-first selector: column timing, bank mask, queue scan,
// and output registers loaded on sel_strobe.
// Assumes: synchronous active-low reset; inputs stable around the strobe edge.
module rowhit_sched
    import rowhit_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int RANKS  = 2,
    parameter int BANKS  = 4,
    parameter int ROWW   = 14,
    parameter int TW     = 16,
    parameter int TRCD   = 4,
    localparam int NB    = RANKS * BANKS,
    localparam int RW    = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int QW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_strobe,
    input  logic                   rd_queue,
    input  logic [TW-1:0]          min_col_at,
    input  logic [TW-1:0]          hidden_act_max,
    input  logic [QDEPTH-1:0]      q_valid,
    input  logic [QDEPTH*RW-1:0]   q_rank,
    input  logic [QDEPTH*BW-1:0]   q_bank,
    input  logic [QDEPTH*ROWW-1:0] q_row,
    input  logic [RANKS-1:0]       rank_ref_idle,
    input  logic [NB-1:0]          bank_open,
    input  logic [NB*ROWW-1:0]     bank_open_row,
    input  logic [NB*TW-1:0]       bank_rd_at,
    input  logic [NB*TW-1:0]       bank_wr_at,
    input  logic [NB*TW-1:0]       bank_act_at,
    output logic                   sel_valid,
    output logic [QW-1:0]          sel_idx,
    output logic [TW-1:0]          sel_col_at,
    output logic [1:0]             sel_kind
);
    logic [NB*TW-1:0] col_ok;
    logic [NB*TW-1:0] miss_col;
    logic [NB-1:0]    mask;
    logic             hidden;
    logic             pick_valid;
    logic [QW-1:0]    pick_idx;
    logic [TW-1:0]    pick_col;
    pick_kind_e       pick_kind;
    pick_kind_e       kind_q;

    rowhit_coltime #(.NB(NB), .TW(TW), .TRCD(TRCD)) u_coltime (
        .rd_queue    (rd_queue),
        .bank_rd_at  (bank_rd_at),
        .bank_wr_at  (bank_wr_at),
        .bank_act_at (bank_act_at),
        .col_ok      (col_ok),
        .miss_col    (miss_col)
    );

    rowhit_bankmask #(.QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS), .TW(TW)) u_mask (
        .q_valid        (q_valid),
        .q_rank         (q_rank),
        .q_bank         (q_bank),
        .rank_ref_idle  (rank_ref_idle),
        .bank_act_at    (bank_act_at),
        .miss_col       (miss_col),
        .min_col_at     (min_col_at),
        .hidden_act_max (hidden_act_max),
        .mask           (mask),
        .hidden         (hidden)
    );

    rowhit_scan #(.QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS),
                  .ROWW(ROWW), .TW(TW)) u_scan (
        .q_valid       (q_valid),
        .q_rank        (q_rank),
        .q_bank        (q_bank),
        .q_row         (q_row),
        .rank_ref_idle (rank_ref_idle),
        .bank_open     (bank_open),
        .bank_open_row (bank_open_row),
        .col_ok        (col_ok),
        .miss_col      (miss_col),
        .mask          (mask),
        .hidden        (hidden),
        .min_col_at    (min_col_at),
        .pick_valid    (pick_valid),
        .pick_idx      (pick_idx),
        .pick_col      (pick_col),
        .pick_kind     (pick_kind)
    );

    // Capture the decision on the strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid  <= 1'b0;
            sel_idx    <= '0;
            sel_col_at <= '0;
            kind_q     <= PICK_NONE;
        end else if (sel_strobe) begin
            sel_valid  <= pick_valid;
            sel_idx    <= pick_idx;
            sel_col_at <= pick_col;
            kind_q     <= pick_kind;
        end
    end

    assign sel_kind = kind_q;
endmodule

// File: rtl/rowhit_sched_chk.sv
// Assertion checker for rowhit_sched, attached by bind.
// Assumes: the same parameters as the bound instance.
module rowhit_sched_chk #(
    parameter int QDEPTH = 16,
    parameter int RANKS  = 2,
    parameter int TW     = 16,
    parameter int QW     = 4,
    parameter int RW     = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_strobe,
    input logic [TW-1:0]        min_col_at,
    input logic [QDEPTH-1:0]    q_valid,
    input logic [QDEPTH*RW-1:0] q_rank,
    input logic [RANKS-1:0]     rank_ref_idle,
    input logic                 sel_valid,
    input logic [QW-1:0]        sel_idx,
    input logic [TW-1:0]        sel_col_at,
    input logic [1:0]           sel_kind
);
    logic [QDEPTH-1:0] ready;
    logic [QDEPTH-1:0] ready_q;
    logic [TW-1:0]     min_col_q;

    // Slots that are eligible at all.
    always_comb begin
        for (int i = 0; i < QDEPTH; i++)
            ready[i] = q_valid[i] && rank_ref_idle[int'(q_rank[i*RW +: RW])];
    end

    // Copies of the inputs seen at the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q   <= '0;
            min_col_q <= '0;
        end else if (sel_strobe) begin
            ready_q   <= ready;
            min_col_q <= min_col_at;
        end
    end

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_strobe |=> ($stable(sel_valid) && $stable(sel_idx) &&
                         $stable(sel_col_at) && $stable(sel_kind))); // R7
    AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ready_q[sel_idx]); // R3
    AST_VALID_IFF_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |=> (sel_valid == (ready_q != '0))); // R6
    AST_SEAMLESS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_kind == 2'd1) |-> (sel_col_at <= min_col_q)); // R1
    AST_PREPPED_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_kind == 2'd2) |-> (sel_col_at > min_col_q)); // R2
endmodule

bind rowhit_sched rowhit_sched_chk #(
    .QDEPTH(QDEPTH), .RANKS(RANKS), .TW(TW), .QW(QW), .RW(RW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_strobe    (sel_strobe),
    .min_col_at    (min_col_at),
    .q_valid       (q_valid),
    .q_rank        (q_rank),
    .rank_ref_idle (rank_ref_idle),
    .sel_valid     (sel_valid),
    .sel_idx       (sel_idx),
    .sel_col_at    (sel_col_at),
    .sel_kind      (sel_kind)
);

// File: tb/tb_rowhit_sched.sv
`timescale 1ns/1ps
module tb_rowhit_sched;
    localparam int Q = 4, RK = 2, BK = 2, ROWW = 8, TW = 8, TRCD = 3;
    localparam int NB = RK * BK;

    logic clk = 1'b0, rst_n = 1'b0, sel_strobe = 1'b0, rd_queue = 1'b1;
    logic [TW-1:0] min_col_at = 8'd10, hidden_act_max = 8'd5;
    logic [Q-1:0] q_valid = '0;
    logic [Q-1:0] q_rank = '0, q_bank = '0;
    logic [Q*ROWW-1:0] q_row = '0;
    logic [RK-1:0] rank_ref_idle = '1;
    logic [NB-1:0] bank_open = '0;
    logic [NB*ROWW-1:0] bank_open_row = '0;
    logic [NB*TW-1:0] bank_rd_at = '0, bank_wr_at = '0, bank_act_at = '0;
    logic sel_valid;
    logic [1:0] sel_idx;
    logic [TW-1:0] sel_col_at;
    logic [1:0] sel_kind;
    int checks = 0, errors = 0;

    rowhit_sched #(.QDEPTH(Q), .RANKS(RK), .BANKS(BK), .ROWW(ROWW), .TW(TW), .TRCD(TRCD)) dut (
        .clk(clk), .rst_n(rst_n), .sel_strobe(sel_strobe), .rd_queue(rd_queue),
        .min_col_at(min_col_at), .hidden_act_max(hidden_act_max),
        .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
        .rank_ref_idle(rank_ref_idle), .bank_open(bank_open), .bank_open_row(bank_open_row),
        .bank_rd_at(bank_rd_at), .bank_wr_at(bank_wr_at), .bank_act_at(bank_act_at),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_col_at(sel_col_at), .sel_kind(sel_kind));

    always #4 clk = ~clk;

    function automatic logic [10:0] ent(input logic v, input logic r, input logic b,
                                        input logic [7:0] row);
        return {v, r, b, row};
    endfunction

    // {exp_valid, exp_idx, exp_kind, exp_col, e3, e2, e1, e0}
    localparam int NV = 7;
    localparam logic [56:0] VEC [NV] = '{
        {1'b1, 2'd1, 2'd1, 8'd8,  11'd0, 11'd0, ent(1,0,0,8'h11), ent(1,0,1,8'h22)}, // R1
        {1'b1, 2'd0, 2'd2, 8'd15, 11'd0, 11'd0, ent(1,0,1,8'h33), ent(1,0,1,8'h22)}, // R2
        {1'b1, 2'd1, 2'd2, 8'd15, 11'd0, 11'd0, ent(1,0,1,8'h22), ent(1,1,0,8'h05)}, // R5 not hidden
        {1'b1, 2'd0, 2'd3, 8'd7,  11'd0, 11'd0, ent(1,0,1,8'h22), ent(1,1,1,8'h07)}, // R5 hidden
        {1'b0, 2'd0, 2'd0, 8'd0,  11'd0, 11'd0, 11'd0,            11'd0},            // R6
        {1'b1, 2'd0, 2'd3, 8'd23, 11'd0, 11'd0, ent(1,0,1,8'h44), ent(1,0,0,8'h99)}, // R4
        {1'b1, 2'd1, 2'd2, 8'd15, 11'd0, 11'd0, ent(1,0,1,8'h22), ent(0,0,0,8'h11)}  // R2
    };
    localparam string VTAG [NV] = '{"R1", "R2", "R5", "R5", "R6", "R4", "R2"};

    task automatic set_bank(input int id, input logic op, input logic [7:0] orow,
                            input logic [7:0] rd, input logic [7:0] wr, input logic [7:0] act);
        bank_open[id] = op;
        bank_open_row[id*ROWW +: ROWW] = orow;
        bank_rd_at[id*TW +: TW] = rd;
        bank_wr_at[id*TW +: TW] = wr;
        bank_act_at[id*TW +: TW] = act;
    endtask

    task automatic base_banks();
        set_bank(0, 1'b1, 8'h11, 8'd8,  8'd12, 8'd20);
        set_bank(1, 1'b1, 8'h22, 8'd15, 8'd15, 8'd20);
        set_bank(2, 1'b0, 8'h00, 8'd0,  8'd0,  8'd6);
        set_bank(3, 1'b0, 8'h00, 8'd0,  8'd0,  8'd4);
        rank_ref_idle = '1;
        rd_queue = 1'b1;
    endtask

    task automatic load_queue(input logic [43:0] q);
        for (int k = 0; k < Q; k++) begin
            q_valid[k] = q[11*k+10];
            q_rank[k]  = q[11*k+9];
            q_bank[k]  = q[11*k+8];
            q_row[k*ROWW +: ROWW] = q[11*k +: 8];
        end
    endtask

    task automatic strobe();
        @(negedge clk) sel_strobe = 1'b1;
        @(negedge clk) sel_strobe = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [1:0] ei,
                       input logic [1:0] ek, input logic [7:0] ec);
        checks++;
        if (sel_valid !== ev || sel_kind !== ek || (ev && (sel_idx !== ei || sel_col_at !== ec))) begin
            errors++;
            $display("FAIL %s: got valid=%0d idx=%0d kind=%0d col=%0d, expected valid=%0d idx=%0d kind=%0d col=%0d",
                     tag, sel_valid, sel_idx, sel_kind, sel_col_at, ev, ei, ek, ec);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        base_banks();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset", 1'b0, 2'd0, 2'd0, 8'd0);
        if (sel_idx !== 2'd0 || sel_col_at !== 8'd0) begin
            checks++; errors++;
            $display("FAIL R8: got idx=%0d col=%0d, expected 0 0", sel_idx, sel_col_at);
        end

        for (int v = 0; v < NV; v++) begin
            base_banks();
            load_queue(VEC[v][43:0]);
            strobe();
            chk(VTAG[v], VEC[v][56], VEC[v][55:54], VEC[v][53:52], VEC[v][51:44]);
        end

        // R3: rank 0 busy, its seamless hit is skipped
        base_banks();
        rank_ref_idle = 2'b10;
        load_queue({11'd0, 11'd0, ent(1,1,1,8'h07), ent(1,0,0,8'h11)});
        strobe();
        chk("R3", 1'b1, 2'd1, 2'd3, 8'd7);

        // R6: only busy-rank entries
        rank_ref_idle = 2'b01;
        load_queue({11'd0, 11'd0, 11'd0, ent(1,1,0,8'h05)});
        strobe();
        chk("R6 busy", 1'b0, 2'd0, 2'd0, 8'd0);

        // R9: early non-seamless bank 1 cleared by seamless bank 2
        base_banks();
        set_bank(1, 1'b1, 8'h22, 8'd15, 8'd15, 8'd2);
        load_queue({11'd0, 11'd0, ent(1,1,0,8'h05), ent(1,0,1,8'h44)});
        strobe();
        chk("R9", 1'b1, 2'd1, 2'd3, 8'd9);

        // R10: write queue uses write time, hit no longer seamless
        base_banks();
        rd_queue = 1'b0;
        load_queue({11'd0, 11'd0, 11'd0, ent(1,0,0,8'h11)});
        strobe();
        chk("R10", 1'b1, 2'd0, 2'd2, 8'd12);

        // R7: inputs change without strobe, outputs hold
        load_queue(44'd0);
        repeat (3) @(negedge clk);
        chk("R7 hold", 1'b1, 2'd0, 2'd2, 8'd12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule